// File: doc/BRIEF.md
# Level-Priority Interrupt Acknowledge Controller

This block ranks up to 63 interrupt request lines for a processor that takes interrupts by level. Each request line has a control register that gives it an interrupt level from 1 to 7 and a priority from 0 to 7 inside that level. Lines 1 to 7 are hard-wired: line n always sits at level n. Inside its level it ranks between the programmable priorities 4 and 3. The block keeps a registered output that holds the highest level now pending. When the processor acknowledges a level, the block picks the strongest pending line at that level. It returns a vector for that line and loads a status byte that records the acknowledged level and priority.

Software programs lines 8 to 63 through a small register port. A 64-bit mask register blocks single lines, and it resets to all ones, so every line starts blocked. The acknowledge port takes a one-cycle strobe and a level. The whole arbitration is combinational, so the vector and the status byte are valid on the cycle after the strobe. Software must give each line a unique level/priority pair. If two enabled lines share one pair, the result is undefined.

Top module: `lpic_top`

## Requirements
- R1: A control register holds the level in bits 5:3 and the priority in bits 2:0. Bits 7:6 read as 0. A write at addresses 8 to 63 takes effect on the next clock. `regRdData` shows the register addressed by `regAddr` in the same cycle.
- R2: Writes to addresses 0 to 7 have no effect. Address n from 1 to 7 reads as level n with priority 0, which is the value 8·n. Address 0 reads 0.
- R3: Reset clears every writable control register to 0. A line whose level is 0 is disabled and never takes part in the level output or in arbitration.
- R4: An acknowledge strobe with level L picks a pending, unmasked line whose level is L. On the next cycle `vectorOut` is 64 plus the line index, and `statusOut` is {1'b0, L[2:0], priority code[3:0]}.
- R5: Inside one level, the line with the higher priority wins. A fixed line ranks below programmable priority 4 and above priority 3, and its status priority code is 8. A programmable line reports its own priority as its code.
- R6: If no line qualifies at level L, the vector is 24 and the status byte is {1'b0, L, 4'd0}.
- R7: `levelOut` is the highest level among pending, unmasked, enabled lines, or 0 if there is none. It is registered, so it follows a change in requests or in programming one clock later.
- R8: A 1 in bit n of the mask blocks line n. The mask resets to all ones and `maskWrEn` writes the whole mask, which takes effect one clock later. Mask bit 0 and `irqReq[0]` have no effect.
- R9: `vectorOut` and `statusOut` reset to 0 and keep their values until the next acknowledge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Control register write strobe |
| regAddr | input | 6 | Control register address, equal to the line index |
| regWrData | input | 8 | Control register write data |
| regRdData | output | 8 | Contents of the addressed control register |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 64 | New mask value; a 1 blocks the line |
| irqReq | input | 64 | Request lines; bit n is line n, bit 0 is unused |
| levelOut | output | 3 | Highest pending level, or 0 |
| ackReq | input | 1 | One-cycle acknowledge strobe |
| ackLevel | input | 3 | Level being acknowledged |
| vectorOut | output | 8 | Vector of the acknowledged line |
| statusOut | output | 8 | Acknowledged level and priority code |

## Verification
A corrupted control register shows up through a different `regRdData` value right away. It also shows up one cycle after a request as the wrong `levelOut`, and one cycle after an acknowledge as the wrong vector. A wrong rank for a fixed line, such as treating it as priority 4 or 3, only appears when the fixed line and its programmable neighbour at the same level request together. The bench drives that case directly. A mask register that ignores writes keeps `levelOut` at 0 and turns every acknowledge into the spurious vector. The very first unmasked sweep catches that.

// File: rtl/lpic_pkg.sv
package lpic_pkg;
  localparam int LVL_W  = 3;
  localparam int PRI_W  = 3;
  localparam int CODE_W = 4;
  localparam int RANK_W = 4;
  localparam logic [CODE_W-1:0] MID_CODE = 4'd8;
  localparam logic [RANK_W-1:0] MID_RANK = 4'd4;

  typedef struct packed {
    logic ctlWe;
    logic maskWe;
    logic ackLoad;
  } strobe_t;
endpackage

// File: rtl/lpic_ctrl.sv
module lpic_ctrl
  import lpic_pkg::*;
#(
  parameter int N_IDX   = 64,
  parameter int N_FIXED = 7,
  localparam int ADDR_W = $clog2(N_IDX)
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              maskWrEn,
  input  logic              ackReq,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] FIRST_RW = ADDR_W'(N_FIXED + 1);

  always_comb begin
    stb.ctlWe   = regWrEn && (regAddr >= FIRST_RW);
    stb.maskWe  = maskWrEn;
    stb.ackLoad = ackReq;
  end
endmodule

// File: rtl/lpic_arb.sv
module lpic_arb
  import lpic_pkg::*;
#(
  parameter int N_IDX   = 64,
  parameter int N_FIXED = 7,
  localparam int ADDR_W = $clog2(N_IDX)
) (
  input  logic [N_IDX-1:0]       pending,
  input  logic [N_IDX*LVL_W-1:0] srcLevel,
  input  logic [N_IDX*PRI_W-1:0] srcPri,
  input  logic [LVL_W-1:0]       ackLevel,
  output logic [LVL_W-1:0]       maxLevel,
  output logic                   hit,
  output logic [ADDR_W-1:0]      winIdx,
  output logic [CODE_W-1:0]      winCode
);
  logic [RANK_W-1:0] rankArr [N_IDX];
  logic [CODE_W-1:0] codeArr [N_IDX];
  logic [LVL_W-1:0]  lvlArr  [N_IDX];

  for (genvar i = 0; i < N_IDX; i++) begin : g_rank
    logic [PRI_W-1:0] p;
    assign p = srcPri[i*PRI_W +: PRI_W];
    assign lvlArr[i] = srcLevel[i*LVL_W +: LVL_W];
    if (i >= 1 && i <= N_FIXED) begin : g_fixed
      assign rankArr[i] = MID_RANK;
      assign codeArr[i] = MID_CODE;
    end else begin : g_prog
      // priorities at or above the mid-point step over it
      assign rankArr[i] = (p < PRI_W'(4)) ? RANK_W'(p) : RANK_W'(p) + RANK_W'(1);
      assign codeArr[i] = CODE_W'(p);
    end
  end

  logic [RANK_W-1:0] bestRank;

  always_comb begin
    maxLevel = '0;
    hit      = 1'b0;
    winIdx   = '0;
    winCode  = '0;
    bestRank = '0;
    for (int i = 1; i < N_IDX; i++) begin
      if (pending[i] && lvlArr[i] != '0) begin
        if (lvlArr[i] > maxLevel) maxLevel = lvlArr[i];
        if (lvlArr[i] == ackLevel && (!hit || rankArr[i] > bestRank)) begin
          hit      = 1'b1;
          bestRank = rankArr[i];
          winIdx   = ADDR_W'(i);
          winCode  = codeArr[i];
        end
      end
    end
  end
endmodule

// File: rtl/lpic_datapath.sv
module lpic_datapath
  import lpic_pkg::*;
#(
  parameter int N_IDX    = 64,
  parameter int N_FIXED  = 7,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  localparam int ADDR_W  = $clog2(N_IDX),
  localparam int CTL_W   = LVL_W + PRI_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [N_IDX-1:0]  maskWrData,
  input  logic [N_IDX-1:0]  irqReq,
  output logic [LVL_W-1:0]  levelOut,
  input  logic [LVL_W-1:0]  ackLevel,
  output logic [VEC_W-1:0]  vectorOut,
  output logic [7:0]        statusOut
);
  logic [N_IDX*LVL_W-1:0] srcLevel;
  logic [N_IDX*PRI_W-1:0] srcPri;
  logic [7:0]             rdArr [N_IDX];
  logic [N_IDX-1:0]       maskReg;

  for (genvar i = 0; i < N_IDX; i++) begin : g_src
    if (i <= N_FIXED) begin : g_ro
      assign srcLevel[i*LVL_W +: LVL_W] = LVL_W'(i);
      assign srcPri[i*PRI_W +: PRI_W]   = '0;
    end else begin : g_rw
      logic [CTL_W-1:0] ctlReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ctlReg <= '0;
        else if (stb.ctlWe && regAddr == ADDR_W'(i)) ctlReg <= regWrData[CTL_W-1:0];
      end
      assign srcLevel[i*LVL_W +: LVL_W] = ctlReg[CTL_W-1:PRI_W];
      assign srcPri[i*PRI_W +: PRI_W]   = ctlReg[PRI_W-1:0];
    end
    assign rdArr[i] = 8'({srcLevel[i*LVL_W +: LVL_W], srcPri[i*PRI_W +: PRI_W]});
  end

  assign regRdData = rdArr[regAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '1;
    else if (stb.maskWe) maskReg <= maskWrData;
  end

  logic [N_IDX-1:0]   pending;
  logic [LVL_W-1:0]   maxLevel;
  logic               hit;
  logic [ADDR_W-1:0]  winIdx;
  logic [CODE_W-1:0]  winCode;

  assign pending = irqReq & ~maskReg & ~N_IDX'(1);

  lpic_arb #(.N_IDX(N_IDX), .N_FIXED(N_FIXED)) u_arb (
    .pending  (pending),
    .srcLevel (srcLevel),
    .srcPri   (srcPri),
    .ackLevel (ackLevel),
    .maxLevel (maxLevel),
    .hit      (hit),
    .winIdx   (winIdx),
    .winCode  (winCode)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelOut <= '0;
    else       levelOut <= maxLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vectorOut <= '0;
      statusOut <= '0;
    end else if (stb.ackLoad) begin
      vectorOut <= hit ? VEC_W'(VEC_BASE) + VEC_W'(winIdx) : VEC_W'(SPUR_VEC);
      statusOut <= {1'b0, ackLevel, hit ? winCode : CODE_W'(0)};
    end
  end

  // R6: no candidate gives the spurious vector with priority code 0
  a_r6_spurious: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackLoad && !hit |=> vectorOut == VEC_W'(SPUR_VEC) && statusOut[3:0] == '0);

  // R4: status carries the acknowledged level, bit 7 clear
  a_r4_status_level: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackLoad |=> statusOut[6:4] == $past(ackLevel) && !statusOut[7]);

  // R5: a fixed winner reports the mid-point code
  a_r5_fixed_mid: assert property (@(posedge clk) disable iff (!rstN)
    stb.ackLoad && hit && winIdx <= ADDR_W'(N_FIXED) |=> statusOut[3:0] == MID_CODE);

  // R7: unchanged inputs keep the level output steady
  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $stable(irqReq) && $stable(maskReg) && !$past(stb.ctlWe)
    |=> $stable(levelOut));

  // R9: without an acknowledge, vector and status hold
  a_r9_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ackLoad |=> $stable(vectorOut) && $stable(statusOut));
endmodule

// File: rtl/lpic_top.sv
module lpic_top
  import lpic_pkg::*;
#(
  parameter int N_IDX    = 64,
  parameter int N_FIXED  = 7,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24,
  localparam int ADDR_W  = $clog2(N_IDX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              maskWrEn,
  input  logic [N_IDX-1:0]  maskWrData,
  input  logic [N_IDX-1:0]  irqReq,
  output logic [2:0]        levelOut,
  input  logic              ackReq,
  input  logic [2:0]        ackLevel,
  output logic [VEC_W-1:0]  vectorOut,
  output logic [7:0]        statusOut
);
  strobe_t stb;

  lpic_ctrl #(.N_IDX(N_IDX), .N_FIXED(N_FIXED)) u_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .maskWrEn (maskWrEn),
    .ackReq   (ackReq),
    .stb      (stb)
  );

  lpic_datapath #(
    .N_IDX(N_IDX), .N_FIXED(N_FIXED), .VEC_W(VEC_W),
    .VEC_BASE(VEC_BASE), .SPUR_VEC(SPUR_VEC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .maskWrData (maskWrData),
    .irqReq     (irqReq),
    .levelOut   (levelOut),
    .ackLevel   (ackLevel),
    .vectorOut  (vectorOut),
    .statusOut  (statusOut)
  );
endmodule

// File: tb/lpic_top_bench.sv
module lpic_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        maskWrEn = 1'b0;
  logic [63:0] maskWrData = '0;
  logic [63:0] irqReq = '0;
  logic [2:0]  levelOut;
  logic        ackReq = 1'b0;
  logic [2:0]  ackLevel = '0;
  logic [7:0]  vectorOut;
  logic [7:0]  statusOut;

  int nChecks = 0;
  int nFails  = 0;
  int bLvl [64];
  int bPri [64];
  logic [63:0] bMask = '1;
  logic [63:0] seed = 64'h9E3779B97F4A7C15;

  always #10 clk = ~clk;

  lpic_top u_lpic_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .maskWrEn(maskWrEn),
    .maskWrData(maskWrData), .irqReq(irqReq), .levelOut(levelOut),
    .ackReq(ackReq), .ackLevel(ackLevel), .vectorOut(vectorOut),
    .statusOut(statusOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] nextRnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic int mLevel(int s);
    if (s == 0) return 0;
    if (s <= 7) return s;
    return bLvl[s];
  endfunction

  function automatic int mRank(int s);
    if (s <= 7) return 4;
    return (bPri[s] < 4) ? bPri[s] : bPri[s] + 1;
  endfunction

  function automatic bit live(int s);
    return irqReq[s] && !bMask[s] && s != 0 && mLevel(s) != 0;
  endfunction

  function automatic int expMax();
    int m = 0;
    for (int s = 1; s < 64; s++) if (live(s) && mLevel(s) > m) m = mLevel(s);
    return m;
  endfunction

  function automatic int expWin(int lv);
    int w = 0;
    for (int s = 1; s < 64; s++)
      if (live(s) && mLevel(s) == lv && (w == 0 || mRank(s) > mRank(w))) w = s;
    return w;
  endfunction

  task automatic wrCtl(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'(a); regWrData = 8'(d);
    @(negedge clk);
    regWrEn = 1'b0;
    if (a >= 8) begin bLvl[a] = (d >> 3) & 7; bPri[a] = d & 7; end
  endtask

  task automatic wrMask(input logic [63:0] m);
    @(negedge clk);
    maskWrEn = 1'b1; maskWrData = m;
    @(negedge clk);
    maskWrEn = 1'b0;
    bMask = m;
  endtask

  task automatic setReq(input logic [63:0] r, input string tag);
    @(negedge clk);
    irqReq = r;
    @(negedge clk);
    check(tag, 64'(levelOut), 64'(expMax()));
  endtask

  task automatic doAck(input int lv, input string tag);
    int w;
    logic [7:0] ev, es;
    w = expWin(lv);
    ev = (w == 0) ? 8'd24 : 8'(64 + w);
    es = {1'b0, 3'(lv), (w == 0) ? 4'd0 : (w <= 7 ? 4'd8 : 4'(bPri[w]))};
    @(negedge clk);
    ackReq = 1'b1; ackLevel = 3'(lv);
    @(negedge clk);
    ackReq = 1'b0;
    check({tag, " vector"}, 64'(vectorOut), 64'(ev));
    check({tag, " status"}, 64'(statusOut), 64'(es));
  endtask

  initial begin
    for (int s = 0; s < 64; s++) begin bLvl[s] = 0; bPri[s] = 0; end
    #1;
    check("R9 reset vector", 64'(vectorOut), 0);
    check("R9 reset status", 64'(statusOut), 0);
    check("R7 reset level", 64'(levelOut), 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R3: writable registers start disabled, fixed ones read 8*n (R2)
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); regAddr = 6'(a); #1;
      check(a <= 7 ? "R2 fixed read" : "R3 reset ctl", 64'(regRdData), (a <= 7) ? 64'(8 * a) : 0);
    end
    // R8: mask starts all ones
    setReq('1, "R8 reset mask blocks all");
    doAck(7, "R8 reset mask ack");
    // R1: program unique level/priority pairs with readback
    for (int a = 8; a < 64; a++) begin
      wrCtl(a, 8'hC0 | (((a - 8) / 8 + 1) << 3) | ((a - 8) % 8));
      regAddr = 6'(a); #1;
      check("R1 ctl readback", 64'(regRdData), 64'(((((a - 8) / 8) + 1) << 3) | ((a - 8) % 8)));
    end
    // R2: fixed registers ignore writes
    for (int a = 0; a < 8; a++) begin
      wrCtl(a, 8'h3F);
      regAddr = 6'(a); #1;
      check("R2 write ignored", 64'(regRdData), 64'(8 * a));
    end
    wrMask('0);
    // R8: line 0 has no effect
    setReq(64'h1, "R8 line0 level");
    doAck(1, "R8 line0 ack");
    // R5: fixed line 3 against priority 3 (line 27) and priority 4 (line 28)
    setReq((64'h1 << 3) | (64'h1 << 27), "R5 mid vs p3 level");
    doAck(3, "R5 mid beats p3");
    setReq((64'h1 << 3) | (64'h1 << 28), "R5 mid vs p4 level");
    doAck(3, "R5 p4 beats mid");
    // R9: outputs hold without a strobe
    setReq(64'h0, "R7 idle level");
    check("R9 hold vector", 64'(vectorOut), 64'(64 + 28));
    check("R9 hold status", 64'(statusOut), 64'h34);
    // R3: disabling a line removes it
    wrCtl(40, 0);
    setReq(64'h1 << 40, "R3 disabled level");
    doAck(5, "R3 disabled ack");
    wrCtl(40, (5 << 3) | 0);
    // R4 R5 R6 R7 R8: sweep request and mask patterns across all levels
    for (int it = 0; it < 160; it++) begin
      logic [63:0] r;
      r = nextRnd();
      if (it % 3 == 1) r = r & nextRnd() & nextRnd();
      if (it >= 60) wrMask(nextRnd() | nextRnd());
      setReq(r, "R7 sweep level");
      for (int lv = 0; lv < 8; lv++) doAck(lv, "R4 sweep ack");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule